// File: doc/BRIEF.md
# Memory Error Capture Registers

This block records the first memory error a system encounters. It watches a stream of completed memory transactions. Each event carries the address, whether a CPU or a DMA engine issued it, whether it was a read or a write, and an error flag with its cause. For each of the two halves of the data word, an event also carries the stored check bits, the computed syndrome and the error-type flags. The ECC logic upstream works out all of these values, and this block only keeps them.

There are two 32-bit registers. The address register latches the first failing transaction. Its valid bit drives a bus-error interrupt. The syndrome register follows the ECC information of every transaction while no error is held. Once the address register becomes valid, the syndrome register freezes, so software finds the syndrome of the failing access. Software reads either register through a select line. Any write strobe to a register clears that register to zero, and this is also how the interrupt is acknowledged.

Top module: `mem_err_capture`

## Requirements
- R1: After reset, both registers read as zero and `bus_err_irq` is low.
- R2: An event with `evt_valid` and `evt_err` high, arriving while the address register is not valid and not being written, loads the address register one clock edge later. The layout is: bit 31 = 1 (valid), bit 30 = `evt_cpu` (1 CPU, 0 DMA), bit 29 = `evt_write` (1 write, 0 read), bit 28 = `evt_ecc` (1 ECC error, 0 timeout or overrun), bits 26:0 = `evt_addr`.
- R3: `bus_err_irq` is high exactly while bit 31 of the address register is set.
- R4: Bit 27 of the address register always reads 0.
- R5: While the address register is valid, further error events are dropped and the register keeps the first error.
- R6: While the address register is not valid, every event with `evt_valid` high loads the syndrome register one edge later, unless that register is written in the same cycle.
- R7: While the address register is valid, the syndrome register is frozen. It holds the data of the event that set the valid bit, because the freeze follows the registered valid bit.
- R8: The syndrome register uses one 16-bit group per half: high half in bits 31:16, low half in bits 15:0. Within a group, bit 15 is that half's error flag, bits 14:8 are its check bits, bit 7 is 1 for a single-bit error and 0 for a double-bit error, and bits 6:0 are its syndrome. Half index 1 of the per-half inputs is the high half. Check-bit and syndrome inputs pack half h at bits [7h+6:7h].
- R9: `reg_wr` high at a clock edge clears the register selected by `reg_sel` to zero (0 = address register, 1 = syndrome register). The other register is not affected.
- R10: A write has priority over an event in the same cycle. An error event that meets an address-register write is lost. An event that meets a syndrome-register write leaves that register zero.
- R11: `reg_rdata` shows the register selected by `reg_sel` in the same cycle, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | A transaction event is present |
| evt_err | input | 1 | The event is an error |
| evt_ecc | input | 1 | Error cause: 1 ECC, 0 timeout/overrun |
| evt_cpu | input | 1 | 1 CPU transaction, 0 DMA |
| evt_write | input | 1 | 1 write transaction, 0 read |
| evt_addr | input | 27 | Transaction address |
| evt_half_err | input | 2 | Per-half error flag |
| evt_half_single | input | 2 | Per-half single-bit (1) / double-bit (0) flag |
| evt_half_chk | input | 14 | Per-half check bits read from memory |
| evt_half_syn | input | 14 | Per-half syndrome |
| reg_wr | input | 1 | Write strobe, clears the selected register |
| reg_sel | input | 1 | Register select: 0 address, 1 syndrome |
| reg_rdata | output | 32 | Selected register contents |
| bus_err_irq | output | 1 | Bus-error interrupt |

## Verification
Register updates from an event or a write strobe take effect at the next rising edge, and the interrupt follows on that same edge. `reg_rdata` is a combinational view of the registered state for the select presented in the current cycle. The bench drives every input on the falling edge and checks 1 ns later. At that point the outputs reflect all edges before the stimulus and none of its own effect. A bench model that advances at each following edge supplies the expected values.

// File: rtl/mec_pkg.sv
package mec_pkg;

    typedef enum logic {
        REG_ADDR = 1'b0,
        REG_SYND = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic cpu;
        logic write;
        logic ecc;
    } mec_attr_t;

endpackage

// File: rtl/mec_half_pack.sv
module mec_half_pack #(
    parameter int CHK_W = 7
) (
    input  logic                 err_i,
    input  logic                 single_i,
    input  logic [CHK_W-1:0]     chk_i,
    input  logic [CHK_W-1:0]     syn_i,
    output logic [2*CHK_W+1:0]   word_o
);
    // group layout: error flag, check bits, single flag, syndrome
    assign word_o = {err_i, chk_i, single_i, syn_i};
endmodule

// File: rtl/mec_synd_reg.sv
module mec_synd_reg #(
    parameter int CHK_W      = 7,
    parameter int NUM_HALVES = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load_i,
    input  logic                              clr_i,
    input  logic [NUM_HALVES-1:0]             half_err_i,
    input  logic [NUM_HALVES-1:0]             half_single_i,
    input  logic [NUM_HALVES*CHK_W-1:0]       half_chk_i,
    input  logic [NUM_HALVES*CHK_W-1:0]       half_syn_i,
    output logic [NUM_HALVES*(2*CHK_W+2)-1:0] reg_o
);
    localparam int HALF_W = 2*CHK_W + 2;
    localparam int REG_W  = NUM_HALVES * HALF_W;

    typedef struct packed {
        logic [REG_W-1:0] word;
    } synd_state_t;

    synd_state_t      state_d, state_q;
    logic [REG_W-1:0] packed_w;

    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
        mec_half_pack #(.CHK_W(CHK_W)) u_half (
            .err_i    (half_err_i[g]),
            .single_i (half_single_i[g]),
            .chk_i    (half_chk_i[g*CHK_W +: CHK_W]),
            .syn_i    (half_syn_i[g*CHK_W +: CHK_W]),
            .word_o   (packed_w[g*HALF_W +: HALF_W])
        );
    end

    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d.word = '0;
        end else if (load_i) begin
            state_d.word = packed_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign reg_o = state_q.word;
endmodule

// File: rtl/mec_addr_reg.sv
module mec_addr_reg #(
    parameter int ADDR_W = 27,
    parameter int REG_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture_i,
    input  logic                clr_i,
    input  mec_pkg::mec_attr_t  attr_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic                valid_o,
    output logic [REG_W-1:0]    reg_o
);
    typedef struct packed {
        logic               valid;
        mec_pkg::mec_attr_t attr;
        logic [ADDR_W-1:0]  addr;
    } addr_state_t;

    addr_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = '0;
        end else if (capture_i && !state_q.valid) begin
            state_d.valid = 1'b1;
            state_d.attr  = attr_i;
            state_d.addr  = addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        reg_o              = '0;
        reg_o[REG_W-1]     = state_q.valid;
        reg_o[REG_W-2]     = state_q.attr.cpu;
        reg_o[REG_W-3]     = state_q.attr.write;
        reg_o[REG_W-4]     = state_q.attr.ecc;
        reg_o[ADDR_W-1:0]  = state_q.addr;
    end

    assign valid_o = state_q.valid;
endmodule

// File: rtl/mem_err_capture.sv
module mem_err_capture #(
    parameter int ADDR_W     = 27,
    parameter int CHK_W      = 7,
    parameter int NUM_HALVES = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              evt_valid,
    input  logic                              evt_err,
    input  logic                              evt_ecc,
    input  logic                              evt_cpu,
    input  logic                              evt_write,
    input  logic [ADDR_W-1:0]                 evt_addr,
    input  logic [NUM_HALVES-1:0]             evt_half_err,
    input  logic [NUM_HALVES-1:0]             evt_half_single,
    input  logic [NUM_HALVES*CHK_W-1:0]       evt_half_chk,
    input  logic [NUM_HALVES*CHK_W-1:0]       evt_half_syn,
    input  logic                              reg_wr,
    input  logic                              reg_sel,
    output logic [NUM_HALVES*(2*CHK_W+2)-1:0] reg_rdata,
    output logic                              bus_err_irq
);
    localparam int REG_W = NUM_HALVES * (2*CHK_W + 2);

    mec_pkg::reg_sel_e  sel_e;
    mec_pkg::mec_attr_t attr_w;
    logic               addr_clr, synd_clr, addr_valid;
    logic [REG_W-1:0]   addr_reg_q, synd_reg_q;

    assign sel_e    = mec_pkg::reg_sel_e'(reg_sel);
    assign addr_clr = reg_wr && (sel_e == mec_pkg::REG_ADDR);
    assign synd_clr = reg_wr && (sel_e == mec_pkg::REG_SYND);
    assign attr_w   = '{cpu: evt_cpu, write: evt_write, ecc: evt_ecc};

    mec_addr_reg #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (evt_valid && evt_err),
        .clr_i     (addr_clr),
        .attr_i    (attr_w),
        .addr_i    (evt_addr),
        .valid_o   (addr_valid),
        .reg_o     (addr_reg_q)
    );

    mec_synd_reg #(.CHK_W(CHK_W), .NUM_HALVES(NUM_HALVES)) u_synd (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (evt_valid && !addr_valid),
        .clr_i         (synd_clr),
        .half_err_i    (evt_half_err),
        .half_single_i (evt_half_single),
        .half_chk_i    (evt_half_chk),
        .half_syn_i    (evt_half_syn),
        .reg_o         (synd_reg_q)
    );

    always_comb begin
        case (sel_e)
            mec_pkg::REG_SYND: reg_rdata = synd_reg_q;
            default:           reg_rdata = addr_reg_q;
        endcase
    end

    assign bus_err_irq = addr_valid;
endmodule

// File: rtl/mec_checker.sv
module mec_checker #(
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_valid,
    input logic             evt_err,
    input logic             reg_wr,
    input logic             reg_sel,
    input logic [REG_W-1:0] addr_reg,
    input logic [REG_W-1:0] synd_reg,
    input logic             irq
);
    logic addr_wr, synd_wr;
    assign addr_wr = reg_wr && !reg_sel;
    assign synd_wr = reg_wr &&  reg_sel;

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_err && !addr_reg[REG_W-1] && !addr_wr) |=> (addr_reg[REG_W-1] && irq));

    assert_irq_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(evt_valid && evt_err));

    assert_first_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_reg[REG_W-1] && !addr_wr) |=> $stable(addr_reg));

    assert_synd_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_reg[REG_W-1] && !synd_wr) |=> $stable(synd_reg));

    assert_addr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr |=> (addr_reg == '0 && !irq));

    assert_synd_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        synd_wr |=> (synd_reg == '0));
endmodule

bind mem_err_capture mec_checker #(.REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_err   (evt_err),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .addr_reg  (addr_reg_q),
    .synd_reg  (synd_reg_q),
    .irq       (bus_err_irq)
);

// File: tb/tb_mem_err_capture.sv
`timescale 1ns/1ps
module tb_mem_err_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 0, evt_err = 0, evt_ecc = 0, evt_cpu = 0, evt_write = 0;
    logic [26:0] evt_addr = '0;
    logic [1:0]  evt_half_err = '0, evt_half_single = '0;
    logic [13:0] evt_half_chk = '0, evt_half_syn = '0;
    logic        reg_wr = 0, reg_sel = 0;
    logic [31:0] reg_rdata;
    logic        bus_err_irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] m_addr = '0, m_synd = '0;

    always #2.5 clk = ~clk;

    mem_err_capture dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pack_synd();
        logic [31:0] w;
        for (int h = 0; h < 2; h++)
            w[h*16 +: 16] = {evt_half_err[h], evt_half_chk[h*7 +: 7],
                             evt_half_single[h], evt_half_syn[h*7 +: 7]};
        return w;
    endfunction

    // Peek: combinational read of the selected register, no clock edge used.
    task automatic peek(input logic sel, input string tag, input logic [31:0] exp);
        reg_wr = 0; evt_valid = 0; reg_sel = sel;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    // One cycle: inputs already driven at a falling edge; model advances at next edge.
    task automatic clock_model();
        logic [31:0] na, ns;
        na = m_addr; ns = m_synd;
        if (reg_wr && !reg_sel) na = '0;
        else if (evt_valid && evt_err && !m_addr[31])
            na = {1'b1, evt_cpu, evt_write, evt_ecc, 1'b0, evt_addr};
        if (reg_wr && reg_sel) ns = '0;
        else if (evt_valid && !m_addr[31]) ns = pack_synd();
        @(negedge clk);
        m_addr = na; m_synd = ns;
        evt_valid = 0; evt_err = 0; reg_wr = 0;
    endtask

    task automatic set_evt(input logic err, ecc, cpu, wt, input logic [26:0] a,
                           input logic [1:0] he, hs, input logic [13:0] hc, hy);
        evt_valid = 1; evt_err = err; evt_ecc = ecc; evt_cpu = cpu; evt_write = wt;
        evt_addr = a; evt_half_err = he; evt_half_single = hs;
        evt_half_chk = hc; evt_half_syn = hy;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0101));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        peek(0, "R1 addr", 32'h0);
        peek(1, "R1 synd", 32'h0);
        chk("R1 irq", {31'b0, bus_err_irq}, 32'h0);

        // R6/R8: read without error loads syndrome; hi err0, lo err1 double
        set_evt(0, 0, 0, 0, 27'h0000123, 2'b01, 2'b00, {7'h7F, 7'h01}, {7'h00, 7'h43});
        clock_model();
        peek(1, "R6 R8 synd after plain read", 32'h7F00_8143);
        peek(0, "R2 no capture without error", 32'h0);

        // R2/R4/R7/R8: error capture
        set_evt(1, 1, 1, 0, 27'h2ABCDEF, 2'b10, 2'b10, {7'h55, 7'h2A}, {7'h0C, 7'h00});
        clock_model();
        peek(0, "R2 R4 captured addr", 32'hD2AB_CDEF);
        chk("R3 irq set", {31'b0, bus_err_irq}, 32'h1);
        peek(1, "R7 R8 synd of failing read", 32'hD58C_2A00);

        // R5/R7: second error dropped, syndrome frozen
        set_evt(1, 0, 0, 1, 27'h0000F0F, 2'b11, 2'b11, 14'h3FFF, 14'h1234);
        clock_model();
        peek(0, "R5 first error kept", 32'hD2AB_CDEF);
        peek(1, "R7 synd frozen", 32'hD58C_2A00);

        // R9: clear syndrome only
        reg_sel = 1; reg_wr = 1;
        clock_model();
        peek(1, "R9 synd cleared", 32'h0);
        peek(0, "R9 addr untouched", 32'hD2AB_CDEF);
        set_evt(0, 0, 0, 0, 27'h1, 2'b11, 2'b11, 14'h3FFF, 14'h3FFF);
        clock_model();
        peek(1, "R7 frozen after clear", 32'h0);

        // R9: clear address, irq drops
        reg_sel = 0; reg_wr = 1;
        clock_model();
        peek(0, "R9 addr cleared", 32'h0);
        chk("R3 irq cleared", {31'b0, bus_err_irq}, 32'h0);

        // R10: error meets address write: lost; syndrome still loads
        set_evt(1, 1, 1, 1, 27'h7FFFFFF, 2'b01, 2'b01, {7'h11, 7'h22}, {7'h33, 7'h44});
        reg_sel = 0; reg_wr = 1;
        clock_model();
        peek(0, "R10 error lost on addr write", 32'h0);
        peek(1, "R6 synd loads on addr write cycle", 32'h1133_A2C4);

        // R10: event meets syndrome write
        set_evt(0, 0, 0, 0, 27'h5, 2'b11, 2'b11, 14'h3FFF, 14'h3FFF);
        reg_sel = 1; reg_wr = 1;
        clock_model();
        peek(1, "R10 synd write wins", 32'h0);

        // R11: read mux tracks select within the cycle
        set_evt(1, 0, 0, 1, 27'h4000001, 2'b00, 2'b00, 14'h0, 14'h0);
        clock_model();
        peek(0, "R11 R4 sel addr", 32'hA400_0001);
        peek(1, "R11 sel synd", 32'h0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            evt_valid       = ($urandom_range(1) == 1);
            evt_err         = ($urandom_range(9) == 0);
            evt_ecc         = $urandom_range(1);
            evt_cpu         = $urandom_range(1);
            evt_write       = $urandom_range(1);
            evt_addr        = 27'($urandom);
            evt_half_err    = 2'($urandom);
            evt_half_single = 2'($urandom);
            evt_half_chk    = 14'($urandom);
            evt_half_syn    = 14'($urandom);
            reg_sel         = $urandom_range(1);
            reg_wr          = ($urandom_range(15) == 0);
            #1;
            if (reg_sel) chk("R6 R7 random synd", reg_rdata, m_synd);
            else         chk("R2 R5 random addr", reg_rdata, m_addr);
            chk("R3 random irq", {31'b0, bus_err_irq}, {31'b0, m_addr[31]});
            clock_model();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule